// File: doc/BRIEF.md
# Banked Expansion ROM Decoder

This block holds the glue logic for an expansion board that keeps up to thirty-one 16 KB ROM banks in one large ROM device. Software writes a ROM number to an I/O port. The block captures that number and decides whether the board owns the upper ROM window. While it does, the block tells the host to switch its own internal ROM off, and it opens the external device for reads.

The five low bits of the captured number select the bank. They go straight onto the ROM's high address lines. The host's fourteen low address lines pass through as the offset inside the bank. Number 0 belongs to the host's own ROM. Numbers of 32 and above belong to other boards. For both, the board stays silent. The chip-enable, output-enable and internal-ROM-disable outputs are combinational from the strobes and the captured number, so they follow the host's access in the same bus cycle. Only the number itself is stored.

Top module: `rombank_decoder`

## Requirements
- R1: After reset the captured ROM number is 0. The bank bits of `rom_addr` read 0, `int_rom_dis` stays low and `rom_ce_n`/`rom_oe_n` stay high even with every strobe asserted.
- R2: While `iorq_n` and `wr_n` are both low and `host_addr[15:8]` equals 0x7E (default match pattern and mask), the value on `host_data` is captured on the rising clock edge. It is visible on the outputs after that edge.
- R3: An I/O write to an address whose bits 15:8 differ from 0x7E leaves the captured number unchanged.
- R4: A write whose `iorq_n` is high leaves the captured number unchanged, such as a memory write with `mreq_n` and `wr_n` low. So does an I/O cycle whose `wr_n` is high.
- R5: `rom_addr[18:14]` equals bits 4:0 of the captured number. `rom_addr[13:0]` equals `host_addr[13:0]`.
- R6: `int_rom_dis` (active high) is high exactly when `romen_n` is low and the captured number is in the range 1 to 31.
- R7: `rom_ce_n` is low exactly when `romen_n` is low and the captured number is in the range 1 to 31.
- R8: `rom_oe_n` is low exactly when `romen_n`, `rd_n` and `mreq_n` are all low and the captured number is in the range 1 to 31.
- R9: For captured numbers 0 and 0x20 to 0xFF, `int_rom_dis` stays low and `rom_ce_n`/`rom_oe_n` stay high under every strobe combination.
- R10: `int_rom_dis`, `rom_ce_n` and `rom_oe_n` respond to a strobe change without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock that samples I/O writes |
| rst_n | input | 1 | Synchronous reset, active low |
| host_addr | input | 16 | Host address bus |
| host_data | input | 8 | Host data bus, write data |
| iorq_n | input | 1 | I/O request, active low |
| mreq_n | input | 1 | Memory request, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| romen_n | input | 1 | Host ROM-window enable, active low |
| rom_addr | output | 19 | ROM device address: bank on 18:14, offset on 13:0 |
| rom_ce_n | output | 1 | ROM chip enable, active low |
| rom_oe_n | output | 1 | ROM output enable, active low |
| int_rom_dis | output | 1 | Disables the host's internal ROM, active high |

## Verification
The assertions check these properties on every cycle:
- A port-matched I/O write lands in the bank bits one edge later.
- Any other cycle leaves the bank bits steady.
- The offset passes through unchanged.
- The disable output and chip enable always agree with each other.
- Output enable never goes active without chip enable, read and memory request.

Some behaviour depends on the numeric value of the captured number, and only the bench scenarios can show it. These are the window edges at 0, 1, 31, 32 and 0xFF, the reset value, and the same-cycle response to the strobes without a clock edge.

// File: rtl/rombank_pkg.sv
// Shared types for the banked expansion ROM decoder.
// Assumes all host strobes are active low.
package rombank_pkg;

    // Host strobes that qualify a ROM read cycle.
    typedef struct packed {
        logic romen_n;
        logic rd_n;
        logic mreq_n;
    } mem_strobe_t;

endpackage

// File: rtl/rombank_sel_reg.sv
// Captures the selected ROM number from a host I/O write to the board port.
// Assumes the write strobes are stable around the sampling clock edge.
// Bits with MASK = 0 are don't-care in the port compare.
module rombank_sel_reg #(
    parameter int              AW    = 16,
    parameter int              DW    = 8,
    parameter logic [AW-1:0]   MATCH = 16'h7E00,
    parameter logic [AW-1:0]   MASK  = 16'hFF00
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] data,
    input  logic          iorq_n,
    input  logic          wr_n,
    output logic [DW-1:0] num
);

    logic [AW-1:0] bit_ok;
    logic          port_hit;
    logic          io_wr;

    // Per-bit port compare; masked-out bits always agree.
    for (genvar g = 0; g < AW; g++) begin : g_cmp
        if (MASK[g]) begin : g_care
            assign bit_ok[g] = (addr[g] == MATCH[g]);
        end else begin : g_dont
            assign bit_ok[g] = 1'b1;
        end
    end

    assign port_hit = &bit_ok;
    assign io_wr    = ~iorq_n & ~wr_n & port_hit;

    // Holds the ROM number; cleared by reset, loaded by a matching I/O write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            num <= '0;
        end else if (io_wr) begin
            num <= data;
        end
    end

endmodule

// File: rtl/rombank_window.sv
// Decides whether the captured ROM number belongs to this board.
// Accepted range is 1 .. 2**BANK_W-1; any higher bit set rejects it.
module rombank_window #(
    parameter int DW     = 8,
    parameter int BANK_W = 5
) (
    input  logic [DW-1:0] num,
    output logic          in_win
);

    logic nonzero;
    logic upper_clear;

    // OR reduction of the bank bits: zero only for bank 0.
    assign nonzero = |num[BANK_W-1:0];

    // Upper bits must all be clear, when the number has any.
    if (DW > BANK_W) begin : g_upper
        assign upper_clear = ~|num[DW-1:BANK_W];
    end else begin : g_noupper
        assign upper_clear = 1'b1;
    end

    assign in_win = nonzero & upper_clear;

endmodule

// File: rtl/rombank_strobe_gen.sv
// Builds ROM chip-enable, output-enable and the internal-ROM disable.
// Purely combinational, so the outputs follow the host strobes in the same cycle.
module rombank_strobe_gen
    import rombank_pkg::*;
(
    input  mem_strobe_t strb,
    input  logic        in_win,
    output logic        ce_n,
    output logic        oe_n,
    output logic        dis
);

    logic sel;

    // Board owns the ROM window: enable asserted and number accepted.
    always_comb begin
        sel  = ~strb.romen_n & in_win;
        dis  = sel;
        ce_n = ~sel;
        oe_n = ~(sel & ~strb.rd_n & ~strb.mreq_n);
    end

endmodule

// File: rtl/rombank_decoder.sv
// Top of the banked expansion ROM decoder.
// A latched ROM number picks one 16 KB bank of a large ROM device.
// The host address provides the offset within the bank.
// Assumes active-low host strobes and a clock fast enough to see each I/O write.
module rombank_decoder #(
    parameter int              AW         = 16,
    parameter int              DW         = 8,
    parameter int              BANK_W     = 5,
    parameter int              OFFS_W     = 14,
    parameter logic [AW-1:0]   PORT_MATCH = 16'h7E00,
    parameter logic [AW-1:0]   PORT_MASK  = 16'hFF00,
    localparam int             ROM_AW     = BANK_W + OFFS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     host_addr,
    input  logic [DW-1:0]     host_data,
    input  logic              iorq_n,
    input  logic              mreq_n,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic              romen_n,
    output logic [ROM_AW-1:0] rom_addr,
    output logic              rom_ce_n,
    output logic              rom_oe_n,
    output logic              int_rom_dis
);

    import rombank_pkg::*;

    logic [DW-1:0] sel_num;
    logic          in_win;
    mem_strobe_t   strb;

    rombank_sel_reg #(
        .AW   (AW),
        .DW   (DW),
        .MATCH(PORT_MATCH),
        .MASK (PORT_MASK)
    ) u_sel (
        .clk   (clk),
        .rst_n (rst_n),
        .addr  (host_addr),
        .data  (host_data),
        .iorq_n(iorq_n),
        .wr_n  (wr_n),
        .num   (sel_num)
    );

    rombank_window #(
        .DW    (DW),
        .BANK_W(BANK_W)
    ) u_win (
        .num   (sel_num),
        .in_win(in_win)
    );

    // Group the read-cycle strobes for the enable logic.
    always_comb begin
        strb.romen_n = romen_n;
        strb.rd_n    = rd_n;
        strb.mreq_n  = mreq_n;
    end

    rombank_strobe_gen u_strb (
        .strb  (strb),
        .in_win(in_win),
        .ce_n  (rom_ce_n),
        .oe_n  (rom_oe_n),
        .dis   (int_rom_dis)
    );

    // Bank bits on top, host offset below.
    assign rom_addr = {sel_num[BANK_W-1:0], host_addr[OFFS_W-1:0]};

endmodule

// File: rtl/rombank_decoder_chk.sv
// Assertion checker for rombank_decoder, attached through bind.
// Observes ports only.
module rombank_decoder_chk #(
    parameter int              AW         = 16,
    parameter int              DW         = 8,
    parameter int              BANK_W     = 5,
    parameter int              OFFS_W     = 14,
    parameter logic [AW-1:0]   PORT_MATCH = 16'h7E00,
    parameter logic [AW-1:0]   PORT_MASK  = 16'hFF00,
    localparam int             ROM_AW     = BANK_W + OFFS_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic [AW-1:0]     host_addr,
    input logic [DW-1:0]     host_data,
    input logic              iorq_n,
    input logic              mreq_n,
    input logic              rd_n,
    input logic              wr_n,
    input logic              romen_n,
    input logic [ROM_AW-1:0] rom_addr,
    input logic              rom_ce_n,
    input logic              rom_oe_n,
    input logic              int_rom_dis
);

    logic wr_hit;
    assign wr_hit = !iorq_n && !wr_n &&
                    ((host_addr & PORT_MASK) == (PORT_MATCH & PORT_MASK));

    // R2: a matching I/O write shows up in the bank bits one edge later.
    p_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit |=> rom_addr[ROM_AW-1:OFFS_W] == $past(host_data[BANK_W-1:0]));

    // R3, R4: any other cycle leaves the bank bits alone.
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_hit |=> $stable(rom_addr[ROM_AW-1:OFFS_W]));

    // R5: the offset passes through unchanged.
    p_offset_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rom_addr[OFFS_W-1:0] == host_addr[OFFS_W-1:0]);

    // R6: the disable output is never high outside the ROM window.
    p_dis_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
        int_rom_dis |-> !romen_n);

    // R7: chip enable and the internal-ROM disable agree.
    p_ce_tracks_r7: assert property (@(posedge clk) disable iff (!rst_n)
        int_rom_dis == !rom_ce_n);

    // R8: output enable needs chip enable, read and memory request.
    p_oe_qual_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !rom_oe_n |-> (!rom_ce_n && !rd_n && !mreq_n));

    // R9: without ROM enable the board stays silent.
    p_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        romen_n |-> (rom_ce_n && rom_oe_n && !int_rom_dis));

endmodule

bind rombank_decoder rombank_decoder_chk #(
    .AW        (AW),
    .DW        (DW),
    .BANK_W    (BANK_W),
    .OFFS_W    (OFFS_W),
    .PORT_MATCH(PORT_MATCH),
    .PORT_MASK (PORT_MASK)
) u_chk (.*);

// File: tb/rombank_decoder_tb.sv
// Directed bench for rombank_decoder. Inputs change on the falling edge.
// Outputs are sampled 5 ns after the falling edge.
module rombank_decoder_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] host_addr;
    logic [7:0]  host_data;
    logic        iorq_n, mreq_n, rd_n, wr_n, romen_n;
    logic [18:0] rom_addr;
    logic        rom_ce_n, rom_oe_n, int_rom_dis;

    int checks   = 0;
    int failures = 0;
    logic [7:0] exp_num = 8'h00;

    always #10 clk = ~clk;   // 50 MHz

    rombank_decoder u_dut (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_data(host_data),
        .iorq_n(iorq_n), .mreq_n(mreq_n), .rd_n(rd_n), .wr_n(wr_n),
        .romen_n(romen_n), .rom_addr(rom_addr), .rom_ce_n(rom_ce_n),
        .rom_oe_n(rom_oe_n), .int_rom_dis(int_rom_dis)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic idle();
        iorq_n = 1; mreq_n = 1; rd_n = 1; wr_n = 1; romen_n = 1;
    endtask

    // One bus cycle of I/O write held across a rising edge.
    task automatic io_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_data = d; iorq_n = 0; wr_n = 0;
        @(negedge clk);
        idle();
        #5;
    endtask

    // ROM read strobes applied with no clock edge in between (R10).
    task automatic check_read(input string tag);
        logic inw;
        inw = (exp_num != 0) && (exp_num < 8'h20);
        idle();
        #1;
        chk({tag, " R9 idle ce"}, rom_ce_n, 1);
        romen_n = 0; #1;
        chk({tag, " R6 dis"}, int_rom_dis, inw);
        chk({tag, " R7 ce"}, rom_ce_n, !inw);
        chk({tag, " R8 oe no rd"}, rom_oe_n, 1);
        rd_n = 0; #1;
        chk({tag, " R8 oe no mreq"}, rom_oe_n, 1);
        mreq_n = 0; #1;
        chk({tag, " R8 R10 oe"}, rom_oe_n, !inw);
        chk({tag, " R5 bank"}, rom_addr[18:14], exp_num[4:0]);
        romen_n = 1; #1;
        chk({tag, " R10 release"}, {int_rom_dis, rom_ce_n, rom_oe_n}, 3'b011);
        idle();
    endtask

    task automatic t_reset();
        @(negedge clk); #5;
        chk("R1 bank after reset", rom_addr[18:14], 0);
        check_read("R1");
    endtask

    task automatic t_select();
        io_write(16'h7E00, 8'h05); exp_num = 8'h05;
        chk("R2 bank 5", rom_addr[18:14], 5);
        check_read("R2 n5");
        io_write(16'h7EA3, 8'h1A); exp_num = 8'h1A;
        chk("R2 low bits ignored in match", rom_addr[18:14], 5'h1A);
        check_read("R2 n1A");
    endtask

    task automatic t_foreign_port();
        io_write(16'h7F00, 8'h03);
        chk("R3 port 7F ignored", rom_addr[18:14], exp_num[4:0]);
        io_write(16'h3E00, 8'h03);
        chk("R3 port 3E ignored", rom_addr[18:14], exp_num[4:0]);
    endtask

    task automatic t_non_io();
        @(negedge clk);
        host_addr = 16'h7E00; host_data = 8'h02; mreq_n = 0; wr_n = 0;
        @(negedge clk); idle(); #5;
        chk("R4 memory write ignored", rom_addr[18:14], exp_num[4:0]);
        @(negedge clk);
        host_addr = 16'h7E00; host_data = 8'h02; iorq_n = 0; rd_n = 0;
        @(negedge clk); idle(); #5;
        chk("R4 I/O read ignored", rom_addr[18:14], exp_num[4:0]);
    endtask

    task automatic t_edges();
        io_write(16'h7E00, 8'h00); exp_num = 8'h00; check_read("R9 n00");
        io_write(16'h7E00, 8'h01); exp_num = 8'h01; check_read("R6 n01");
        io_write(16'h7E00, 8'h1F); exp_num = 8'h1F; check_read("R6 n1F");
        io_write(16'h7E00, 8'h20); exp_num = 8'h20; check_read("R9 n20");
        io_write(16'h7E00, 8'hFF); exp_num = 8'hFF; check_read("R9 nFF");
        io_write(16'h7E00, 8'h45); exp_num = 8'h45; check_read("R9 n45");
    endtask

    task automatic t_offset();
        io_write(16'h7E00, 8'h0C); exp_num = 8'h0C;
        for (int i = 0; i < 4; i++) begin
            logic [15:0] a;
            a = 16'h3FFF >> (i * 3);
            a = a ^ (16'hC000 >> i);
            host_addr = a; #2;
            chk("R5 offset", rom_addr[13:0], a[13:0]);
            chk("R5 bank hold", rom_addr[18:14], 5'h0C);
        end
    endtask

    initial begin
        idle();
        host_addr = 16'h0000; host_data = 8'h00;
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_select();
        t_foreign_port();
        t_non_io();
        t_edges();
        t_offset();
        // Reset again returns to number 0 (R1).
        io_write(16'h7E00, 8'h09);
        @(negedge clk); rst_n = 0;
        @(negedge clk); rst_n = 1; exp_num = 8'h00; #5;
        chk("R1 re-reset bank", rom_addr[18:14], 0);
        check_read("R1 re-reset");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #1000000;
        failures++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule